// File: doc/BRIEF.md
# Windowed Address Partition Translator

The block maps a fixed, contiguous virtual address space onto four movable windows of a device's physical address space. Firmware programs a physical start for every window, and a size for the first three, through a single-cycle register-write port. Each virtual request is decoded into the window it falls in. It is then rebased onto that window's physical start, and the access is marked as a register access when it lands in the register window.

The virtual layout is not programmed directly. It follows from the sizes. Window 0 (memory) starts at virtual 0. Window 1 (registers) follows it. Window 2 (memory) follows window 1. Window 3 (memory) is open-ended and runs from the end of window 2 up to the top of the virtual space, `VIRT_LIMIT`. The physical starts are independent of each other and of the virtual layout. An address at or above `VIRT_LIMIT` misses. All results are registered and appear one cycle after the request.

Top module: `part_xlate`

## Requirements
- R1: After reset all starts and sizes are zero and every output is low. A request then resolves to window 3, and its physical address equals its virtual address.
- R2: `rsp_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high. In any cycle where `rsp_valid_o` is low, the miss flag, the window index, the register flag and the physical address are all zero.
- R3: With sizes S0, S1, S2, window 0 covers virtual [0, S0), window 1 covers [S0, S0+S1), window 2 covers [S0+S1, S0+S1+S2), and window 3 covers [S0+S1+S2, VIRT_LIMIT). The sums are formed without wrap-around.
- R4: The physical address is the window's start plus (virtual address minus the window's virtual base), taken modulo 2^ADDR_W.
- R5: `rsp_is_reg_o` is high exactly for a hit in window 1 (`rsp_win_o` = 1).
- R6: A request with a virtual address at or above VIRT_LIMIT gives `rsp_miss_o` = 1, with physical address 0, window 0 and register flag 0. Every address below VIRT_LIMIT hits a window.
- R7: A window among 0 to 2 whose size is zero never matches, so its virtual base goes to the next window. When ranges coincide, the lowest index wins.
- R8: Configuration writes use `cfg_addr_i` = {window[1:0], field}, where field 0 selects the start and field 1 selects the size. A write to address 7 (the size of window 3) has no effect.
- R9: A configuration write is first used by a request issued in the cycle after the write. A request issued in the same cycle as the write is translated with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | {window index, field}; field 0 = start, 1 = size |
| cfg_wdata_i | input | ADDR_W | Configuration write data |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | ADDR_W | Virtual address |
| rsp_valid_o | output | 1 | Result valid, one cycle after request |
| rsp_paddr_o | output | ADDR_W | Physical address (0 on miss) |
| rsp_win_o | output | 2 | Index of the window hit |
| rsp_is_reg_o | output | 1 | Hit is in the register window |
| rsp_miss_o | output | 1 | Address fell in no window |

## Verification
A configuration write and a translation can fall in the same clock cycle. The translation must then use the old window values, and a request in the following cycle must use the new ones. The bench provokes this in directed steps: it rewrites a start or a size while a request to the affected window is issued. It also does so in random steps that drive both ports together. Its model predicts each result from the values before the write and applies the write only after the clock edge, so using the new values a cycle early shows up as a mismatch.

// File: rtl/part_xlate_pkg.sv
package part_xlate_pkg;
  localparam int unsigned NUM_WIN = 4;
  localparam int unsigned WIN_W   = 2;
  localparam int unsigned REG_WIN = 1;
  localparam int unsigned CFG_AW  = 3;

  typedef enum logic {
    FLD_START = 1'b0,
    FLD_SIZE  = 1'b1
  } cfg_fld_e;
endpackage

// File: rtl/part_xlate_cfg.sv
module part_xlate_cfg
  import part_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 we_i,
  input  logic [CFG_AW-1:0]                    addr_i,
  input  logic [ADDR_W-1:0]                    wdata_i,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]       start_o,
  output logic [NUM_WIN-2:0][ADDR_W-1:0]       size_o
);
  logic [WIN_W-1:0] wsel;
  cfg_fld_e         fld;

  assign wsel = addr_i[CFG_AW-1:1];
  assign fld  = cfg_fld_e'(addr_i[0]);

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) start_o[k] <= '0;
      else if (we_i && fld == FLD_START && wsel == WIN_W'(k)) start_o[k] <= wdata_i;
    end
    // open-ended last window keeps no size
    if (k < NUM_WIN - 1) begin : g_size
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) size_o[k] <= '0;
        else if (we_i && fld == FLD_SIZE && wsel == WIN_W'(k)) size_o[k] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/part_xlate_dec.sv
module part_xlate_dec
  import part_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned VIRT_LIMIT = 32'h0100_0000
) (
  input  logic [ADDR_W-1:0]              vaddr_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] start_i,
  input  logic [NUM_WIN-2:0][ADDR_W-1:0] size_i,
  output logic                           hit_o,
  output logic [WIN_W-1:0]               win_o,
  output logic                           is_reg_o,
  output logic [ADDR_W-1:0]              paddr_o
);
  // two guard bits hold the sum of three sizes without wrap
  localparam int unsigned EXT_W = ADDR_W + 2;
  localparam logic [EXT_W-1:0] LIMIT_X = EXT_W'(VIRT_LIMIT);

  logic [EXT_W-1:0]              va_x;
  logic [NUM_WIN-1:0][EXT_W-1:0] base;
  logic [NUM_WIN-1:0][EXT_W-1:0] off;
  logic [NUM_WIN-1:0]            in_rng;
  logic                          in_space;
  logic [WIN_W-1:0]              sel;
  logic [EXT_W-1:0]              sel_off;

  assign va_x     = EXT_W'(vaddr_i);
  assign in_space = va_x < LIMIT_X;
  assign base[0]  = '0;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    if (k > 0) begin : g_base
      assign base[k] = base[k-1] + EXT_W'(size_i[k-1]);
    end
    assign off[k] = va_x - base[k];
    if (k < NUM_WIN - 1) begin : g_bounded
      assign in_rng[k] = in_space && (va_x >= base[k]) && (off[k] < EXT_W'(size_i[k]));
    end else begin : g_open
      assign in_rng[k] = in_space && (va_x >= base[k]);
    end
  end

  always_comb begin
    sel = '0;
    for (int k = NUM_WIN - 1; k >= 0; k--) begin
      if (in_rng[k]) sel = WIN_W'(k);
    end
  end

  assign sel_off  = off[sel];
  assign hit_o    = |in_rng;
  assign win_o    = hit_o ? sel : '0;
  assign is_reg_o = hit_o && (sel == WIN_W'(REG_WIN));
  assign paddr_o  = hit_o ? ADDR_W'(EXT_W'(start_i[sel]) + sel_off) : '0;
endmodule

// File: rtl/part_xlate_out.sv
module part_xlate_out
  import part_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              hit_i,
  input  logic [WIN_W-1:0]  win_i,
  input  logic              is_reg_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output logic              valid_o,
  output logic              miss_o,
  output logic [WIN_W-1:0]  win_o,
  output logic              is_reg_o,
  output logic [ADDR_W-1:0] paddr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      miss_o   <= 1'b0;
      win_o    <= '0;
      is_reg_o <= 1'b0;
      paddr_o  <= '0;
    end else begin
      valid_o  <= valid_i;
      miss_o   <= valid_i && !hit_i;
      win_o    <= valid_i ? win_i : '0;
      is_reg_o <= valid_i && is_reg_i;
      paddr_o  <= valid_i ? paddr_i : '0;
    end
  end
endmodule

// File: rtl/part_xlate.sv
module part_xlate
  import part_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned VIRT_LIMIT = 32'h0100_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic [1:0]        rsp_win_o,
  output logic              rsp_is_reg_o,
  output logic              rsp_miss_o
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] start_q;
  logic [NUM_WIN-2:0][ADDR_W-1:0] size_q;
  logic                           d_hit;
  logic [WIN_W-1:0]               d_win;
  logic                           d_is_reg;
  logic [ADDR_W-1:0]              d_paddr;

  part_xlate_cfg #(.ADDR_W(ADDR_W)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .start_o (start_q),
    .size_o  (size_q)
  );

  part_xlate_dec #(.ADDR_W(ADDR_W), .VIRT_LIMIT(VIRT_LIMIT)) i_dec (
    .vaddr_i  (req_vaddr_i),
    .start_i  (start_q),
    .size_i   (size_q),
    .hit_o    (d_hit),
    .win_o    (d_win),
    .is_reg_o (d_is_reg),
    .paddr_o  (d_paddr)
  );

  part_xlate_out #(.ADDR_W(ADDR_W)) i_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (req_valid_i),
    .hit_i    (d_hit),
    .win_i    (d_win),
    .is_reg_i (d_is_reg),
    .paddr_i  (d_paddr),
    .valid_o  (rsp_valid_o),
    .miss_o   (rsp_miss_o),
    .win_o    (rsp_win_o),
    .is_reg_o (rsp_is_reg_o),
    .paddr_o  (rsp_paddr_o)
  );
endmodule

// File: rtl/part_xlate_chk.sv
module part_xlate_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned VIRT_LIMIT = 32'h0100_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_vaddr_i,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] rsp_paddr_o,
  input logic [1:0]        rsp_win_o,
  input logic              rsp_is_reg_o,
  input logic              rsp_miss_o
);
  logic out_space;
  assign out_space = {1'b0, req_vaddr_i} >= (ADDR_W+1)'(VIRT_LIMIT);

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_miss_o && !rsp_is_reg_o &&
                      rsp_win_o == 2'd0 && rsp_paddr_o == '0));

  a_r6_limit_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && out_space) |=> (rsp_miss_o && !rsp_is_reg_o &&
                                    rsp_win_o == 2'd0 && rsp_paddr_o == '0));

  a_r6_space_covered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !out_space) |=> !rsp_miss_o);

  a_r5_reg_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_is_reg_o |-> (rsp_valid_o && !rsp_miss_o && rsp_win_o == 2'd1));
endmodule

bind part_xlate part_xlate_chk #(.ADDR_W(ADDR_W), .VIRT_LIMIT(VIRT_LIMIT)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_vaddr_i  (req_vaddr_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_paddr_o  (rsp_paddr_o),
  .rsp_win_o    (rsp_win_o),
  .rsp_is_reg_o (rsp_is_reg_o),
  .rsp_miss_o   (rsp_miss_o)
);

// File: tb/test_part_xlate.sv
`timescale 1ns/1ps
module test_part_xlate;
  localparam int unsigned AW    = 32;
  localparam longint      LIMIT = 64'h0100_0000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [2:0]    cfg_addr_i = '0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_vaddr_i = '0;
  logic          rsp_valid_o;
  logic [AW-1:0] rsp_paddr_o;
  logic [1:0]    rsp_win_o;
  logic          rsp_is_reg_o;
  logic          rsp_miss_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  longint st [4];
  longint sz [3];

  always #2 clk_i = ~clk_i;

  part_xlate #(.ADDR_W(AW), .VIRT_LIMIT(32'h0100_0000)) i_part_xlate (.*);

  // {miss, win, is_reg, paddr}
  function automatic logic [35:0] exp_xl(logic [31:0] v);
    longint b = 0;
    longint vv = longint'(v);
    if (vv >= LIMIT) return {1'b1, 35'b0};
    for (int k = 0; k < 4; k++) begin
      if (k < 3) begin
        if (sz[k] != 0 && vv >= b && vv < b + sz[k])
          return {1'b0, 2'(k), (k == 1), 32'(st[k] + (vv - b))};
        b += sz[k];
      end else if (vv >= b) begin
        return {1'b0, 2'd3, 1'b0, 32'(st[3] + (vv - b))};
      end
    end
    return {1'b1, 35'b0};
  endfunction

  function automatic longint vbase(int k);
    longint b = 0;
    for (int j = 0; j < k; j++) b += sz[j];
    return b;
  endfunction

  task automatic model_write(logic [2:0] a, logic [31:0] d);
    if (a[0] == 1'b0) st[a[2:1]] = longint'(d);
    else if (a[2:1] != 2'd3) sz[a[2:1]] = longint'(d);
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic step(bit dc, logic [2:0] ca, logic [31:0] cd,
                      bit dr, logic [31:0] va, string tag);
    logic [36:0] want, got;
    cfg_we_i = dc; cfg_addr_i = ca; cfg_wdata_i = cd;
    req_valid_i = dr; req_vaddr_i = va;
    want = dr ? {1'b1, exp_xl(va)} : 37'b0;
    @(posedge clk_i);
    if (dc) model_write(ca, cd);
    @(negedge clk_i);
    got = {rsp_valid_o, rsp_miss_o, rsp_win_o, rsp_is_reg_o, rsp_paddr_o};
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s vaddr=%h got=%h exp=%h", tag, va, got, want);
    end
    cfg_we_i = 1'b0; req_valid_i = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    step(1'b1, a, d, 1'b0, '0, "R2");
  endtask

  task automatic rd(logic [31:0] va, string tag);
    step(1'b0, '0, '0, 1'b1, va, tag);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) st[k] = 0;
    for (int k = 0; k < 3; k++) sz[k] = 0;
    repeat (3) @(negedge clk_i);
    n_chk++;
    if ({rsp_valid_o, rsp_miss_o, rsp_win_o, rsp_is_reg_o, rsp_paddr_o} !== 37'b0) begin
      n_bad++;
      $display("FAIL R1 reset outputs got=%h exp=0",
               {rsp_valid_o, rsp_miss_o, rsp_win_o, rsp_is_reg_o, rsp_paddr_o});
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: all-zero config maps identity through window 3
    rd(32'h0000_1234, "R1");
    n_chk++;
    if (rsp_win_o !== 2'd3 || rsp_paddr_o !== 32'h0000_1234) begin
      n_bad++;
      $display("FAIL R1 win=%0d paddr=%h exp win=3 paddr=00001234", rsp_win_o, rsp_paddr_o);
    end
    step(1'b0, '0, '0, 1'b0, '0, "R2");

    // directed layout
    wr(3'd0, 32'h8000_0000); wr(3'd1, 32'h0000_1000);
    wr(3'd2, 32'h0040_0000); wr(3'd3, 32'h0000_0200);
    wr(3'd4, 32'h2000_0000); wr(3'd5, 32'h0000_3000);
    wr(3'd6, 32'h9000_0000);
    rd(32'h0000_0000, "R3"); rd(32'h0000_0FFF, "R3");
    rd(32'h0000_1000, "R5");
    n_chk++;
    if (!rsp_is_reg_o || rsp_paddr_o !== 32'h0040_0000) begin
      n_bad++;
      $display("FAIL R5 is_reg=%0d paddr=%h exp 1 00400000", rsp_is_reg_o, rsp_paddr_o);
    end
    rd(32'h0000_11FF, "R5"); rd(32'h0000_1200, "R3");
    rd(32'h0000_41FF, "R3"); rd(32'h0000_4200, "R3");
    n_chk++;
    if (rsp_win_o !== 2'd3 || rsp_paddr_o !== 32'h9000_0000) begin
      n_bad++;
      $display("FAIL R3 win=%0d paddr=%h exp 3 90000000", rsp_win_o, rsp_paddr_o);
    end
    rd(32'h00FF_FFFF, "R3");
    // R6: outside the virtual space
    rd(32'h0100_0000, "R6"); rd(32'hFFFF_FFFF, "R6");
    // R4: physical wrap
    wr(3'd6, 32'hFFFF_FFF0);
    rd(32'h0000_4220, "R4");
    n_chk++;
    if (rsp_paddr_o !== 32'h0000_0010) begin
      n_bad++;
      $display("FAIL R4 paddr=%h exp=00000010", rsp_paddr_o);
    end
    // R8: size of window 3 has no effect
    wr(3'd7, 32'h0000_5555);
    rd(32'h0000_4220, "R8"); rd(32'h00FF_FFF0, "R8");
    // R7: zero-size windows skipped
    wr(3'd3, 32'h0);
    rd(32'h0000_1000, "R7");
    n_chk++;
    if (rsp_win_o !== 2'd2) begin
      n_bad++;
      $display("FAIL R7 win=%0d exp=2", rsp_win_o);
    end
    wr(3'd1, 32'h0);
    rd(32'h0000_0000, "R7");
    // R9: write and request in the same cycle
    wr(3'd1, 32'h0000_1000);
    step(1'b1, 3'd0, 32'h1111_0000, 1'b1, 32'h0000_0010, "R9");
    n_chk++;
    if (rsp_paddr_o !== 32'h8000_0010) begin
      n_bad++;
      $display("FAIL R9 same-cycle paddr=%h exp=80000010", rsp_paddr_o);
    end
    rd(32'h0000_0010, "R9");
    step(1'b1, 3'd1, 32'h0000_0800, 1'b1, 32'h0000_0900, "R9");
    rd(32'h0000_0900, "R9");

    // constrained random
    void'($urandom(32'd12345));
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] va, cd;
      logic [2:0]  ca;
      int          pick;
      bit          dc;
      pick = int'($urandom_range(0, 9));
      dc = ($urandom_range(0, 7) == 0);
      ca = 3'($urandom_range(0, 7));
      cd = ca[0] ? (($urandom_range(0, 3) == 0) ? 32'h0 : $urandom_range(1, 32'h0060_0000))
                 : $urandom;
      if (pick < 4) begin
        int  k = int'($urandom_range(0, 3));
        longint b = vbase(k) + longint'($urandom_range(0, 2)) - 1;
        va = (b < 0) ? 32'h0 : 32'(b);
      end else if (pick == 4) begin
        va = 32'(LIMIT - 1 + longint'($urandom_range(0, 1)));
      end else begin
        va = $urandom_range(0, 32'h0120_0000);
      end
      step(dc, ca, cd, ($urandom_range(0, 5) != 0), va,
           dc ? "R9" : ((va >= 32'h0100_0000) ? "R6" : "R4"));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog expired got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule